// File: doc/BRIEF.md
# Nibble-Serial Header Parity Generator

This block produces the 8-bit error-correction parity byte that protects the header bytes of a secondary data packet. A 32-bit input word is accepted with a start pulse while the block is ready. The word is then consumed four bits per clock by a two-register feedback structure over 4-bit symbols. When the last symbol has been absorbed, the parity byte is presented together with a one-cycle done strobe. A word whose value fits in its low byte is processed in two symbol steps. A wider word is processed in eight.

A small combinational packer sits beside the generator. It places header bytes and their parity bytes into two 32-bit register images. The first image holds header byte 1 with its parity and header byte 2 with its parity. The second image holds header byte 3 with its parity.

The controller is a three-state machine:
- `ST_IDLE`: ready, waiting.
- `ST_RUN`: one symbol step per clock.
- `ST_DONE`: result shown, done strobe high.

Its transitions are:
- GO: `ST_IDLE` to `ST_RUN` on an accepted start.
- STEP: `ST_RUN` to `ST_RUN` while symbols remain.
- LAST: `ST_RUN` to `ST_DONE` on the final symbol.
- RETIRE: `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `hdr_parity_gen`

## Requirements
- R1: Symbols are taken from the word latched at start, least significant nibble first, moving up four bits per step. The step count is 8 when the word is greater than 0xFF and 2 otherwise.
- R2: Two 4-bit registers a and b are cleared at start. Each step computes c = nibble XOR b, then sets b to a XOR H(c) and a to F(c). In these maps, bit k of the result is written fk. F(c) = {f3=c2, f2=c1, f1=c0^c3, f0=c3}. H(c) = {h3=c2^c3, h2=c1^c2, h1=c0^c1^c3, h0=c0^c3}.
- R3: The parity byte is {a, b}, with a in bits 7:4 and b in bits 3:0.
- R4: ready_o is high only in `ST_IDLE`. A start seen while ready_o is high is accepted on that clock edge. done_o then rises on the N-th following edge, where N is the step count. ready_o returns high one edge later.
- R5: A start seen while ready_o is low is ignored. Neither the result nor the timing of the computation in flight changes.
- R6: done_o is high for exactly one cycle per accepted start. parity_o changes only on the edge where done_o rises, and holds its value otherwise.
- R7: A synchronous active-high reset returns the block to `ST_IDLE` with ready_o=1, done_o=0 and parity_o=0. This applies also when the reset arrives in the middle of a computation.
- R8: pack_a_o = {par1_i, hdr1_i, par2_i, hdr2_i}. So header byte 1 is in bits 23:16 with its parity in 31:24, and header byte 2 is in bits 7:0 with its parity in 15:8.
- R9: pack_b_o = {par3_i, hdr3_i, 16'h0000}. So header byte 3 is in bits 23:16, its parity is in 31:24, and bits 15:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured only while ready |
| word_i | input | 32 | Header word to protect |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle completion strobe |
| parity_o | output | 8 | Parity byte {a, b} |
| hdr1_i | input | 8 | Header byte 1 for packing |
| hdr2_i | input | 8 | Header byte 2 for packing |
| hdr3_i | input | 8 | Header byte 3 for packing |
| par1_i | input | 8 | Parity of header byte 1 |
| par2_i | input | 8 | Parity of header byte 2 |
| par3_i | input | 8 | Parity of header byte 3 |
| pack_a_o | output | 32 | Image holding header bytes 1 and 2 with parities |
| pack_b_o | output | 32 | Image holding header byte 3 with parity |

## Verification
Each input pattern separates a different kind of fault:
- The all-zero word shows whether the registers start cleared.
- 0xFF is the largest two-step word.
- 0x100 is the smallest eight-step word, so the pair exposes an off-by-one in the length decision and in the step count.
- Random 32-bit words exercise both feedback maps across all nibble positions. They also show whether symbols are taken in the wrong order.
- A start held high continuously, and pulses that arrive mid-run with a changing word, show whether starts during a computation leak into its result or its timing.
- A reset applied in the middle of a computation checks recovery to the idle state.

// File: rtl/hdr_parity_pkg.sv
package hdr_parity_pkg;

    localparam int SYM_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } hp_state_e;

    // upper-register feedback map
    function automatic logic [SYM_W-1:0] sym_f(input logic [SYM_W-1:0] c);
        return {c[2], c[1], c[0] ^ c[3], c[3]};
    endfunction

    // lower-register feedback map
    function automatic logic [SYM_W-1:0] sym_h(input logic [SYM_W-1:0] c);
        return {c[2] ^ c[3], c[1] ^ c[2], c[0] ^ c[1] ^ c[3], c[0] ^ c[3]};
    endfunction

endpackage

// File: rtl/hdr_parity_ctrl.sv
module hdr_parity_ctrl
    import hdr_parity_pkg::*;
#(
    parameter int LONG_SYMS  = 8,
    parameter int SHORT_SYMS = 2,
    localparam int IDX_W = (LONG_SYMS > 1) ? $clog2(LONG_SYMS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             long_i,
    output logic             load_o,
    output logic             step_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             ready_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LONG_END  = IDX_W'(LONG_SYMS - 1);
    localparam logic [IDX_W-1:0] SHORT_END = IDX_W'(SHORT_SYMS - 1);

    hp_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             long_q;

    // state register and step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_o) begin
                idx_q  <= '0;
                long_q <= long_i;
            end else if (step_o) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // next state: GO, STEP, LAST, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (last_o)  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o  = 1'b0;
        step_o  = 1'b0;
        last_o  = 1'b0;
        ready_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o = 1'b1;
                load_o  = start_i;
            end
            ST_RUN: begin
                step_o = 1'b1;
                last_o = (idx_q == (long_q ? LONG_END : SHORT_END));
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/hdr_parity_core.sv
module hdr_parity_core
    import hdr_parity_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int SHORT_SYMS = 2,
    localparam int LONG_SYMS  = WORD_W / SYM_W,
    localparam int SHORT_BITS = SHORT_SYMS * SYM_W,
    localparam int IDX_W      = (LONG_SYMS > 1) ? $clog2(LONG_SYMS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               load_i,
    input  logic               step_i,
    input  logic               last_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic               long_o,
    output logic [2*SYM_W-1:0] parity_o
);

    logic [WORD_W-1:0]  word_q;
    logic [SYM_W-1:0]   a_q, b_q;
    logic [SYM_W-1:0]   nib, c, a_d, b_d;
    logic [2*SYM_W-1:0] res_q;

    // a word with any bit above the short span needs the long run
    assign long_o = |word_i[WORD_W-1:SHORT_BITS];

    always_comb begin
        nib = word_q[int'(idx_i)*SYM_W +: SYM_W];
        c   = nib ^ b_q;
        a_d = sym_f(c);
        b_d = a_q ^ sym_h(c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            res_q  <= '0;
        end else if (load_i) begin
            word_q <= word_i;
            a_q    <= '0;
            b_q    <= '0;
        end else if (step_i) begin
            a_q <= a_d;
            b_q <= b_d;
            if (last_i) res_q <= {a_d, b_d};
        end
    end

    assign parity_o = res_q;

endmodule

// File: rtl/hdr_parity_pack.sv
module hdr_parity_pack #(
    parameter int BYTE_W = 8,
    localparam int IMG_W = 4 * BYTE_W
) (
    input  logic [BYTE_W-1:0] hdr1_i,
    input  logic [BYTE_W-1:0] hdr2_i,
    input  logic [BYTE_W-1:0] hdr3_i,
    input  logic [BYTE_W-1:0] par1_i,
    input  logic [BYTE_W-1:0] par2_i,
    input  logic [BYTE_W-1:0] par3_i,
    output logic [IMG_W-1:0]  pack_a_o,
    output logic [IMG_W-1:0]  pack_b_o
);

    assign pack_a_o = {par1_i, hdr1_i, par2_i, hdr2_i};
    assign pack_b_o = {par3_i, hdr3_i, {(2*BYTE_W){1'b0}}};

endmodule

// File: rtl/hdr_parity_gen.sv
module hdr_parity_gen
    import hdr_parity_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int SHORT_SYMS = 2,
    parameter int BYTE_W     = 8,
    localparam int LONG_SYMS = WORD_W / SYM_W,
    localparam int IDX_W     = (LONG_SYMS > 1) ? $clog2(LONG_SYMS) : 1,
    localparam int PAR_W     = 2 * SYM_W,
    localparam int IMG_W     = 4 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [PAR_W-1:0]  parity_o,
    input  logic [BYTE_W-1:0] hdr1_i,
    input  logic [BYTE_W-1:0] hdr2_i,
    input  logic [BYTE_W-1:0] hdr3_i,
    input  logic [BYTE_W-1:0] par1_i,
    input  logic [BYTE_W-1:0] par2_i,
    input  logic [BYTE_W-1:0] par3_i,
    output logic [IMG_W-1:0]  pack_a_o,
    output logic [IMG_W-1:0]  pack_b_o
);

    logic             load, step, last, is_long;
    logic [IDX_W-1:0] idx;

    hdr_parity_ctrl #(
        .LONG_SYMS (LONG_SYMS),
        .SHORT_SYMS(SHORT_SYMS)
    ) i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .long_i (is_long),
        .load_o (load),
        .step_o (step),
        .last_o (last),
        .idx_o  (idx),
        .ready_o(ready_o),
        .done_o (done_o)
    );

    hdr_parity_core #(
        .WORD_W    (WORD_W),
        .SHORT_SYMS(SHORT_SYMS)
    ) i_core (
        .clk     (clk),
        .rst     (rst),
        .word_i  (word_i),
        .load_i  (load),
        .step_i  (step),
        .last_i  (last),
        .idx_i   (idx),
        .long_o  (is_long),
        .parity_o(parity_o)
    );

    hdr_parity_pack #(
        .BYTE_W(BYTE_W)
    ) i_pack (
        .hdr1_i  (hdr1_i),
        .hdr2_i  (hdr2_i),
        .hdr3_i  (hdr3_i),
        .par1_i  (par1_i),
        .par2_i  (par2_i),
        .par3_i  (par3_i),
        .pack_a_o(pack_a_o),
        .pack_b_o(pack_b_o)
    );

endmodule

// File: rtl/hdr_parity_chk.sv
module hdr_parity_chk #(
    parameter int PAR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             ready_o,
    input logic             done_o,
    input logic [PAR_W-1:0] parity_o
);

    assert_accept_leaves_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i) |=> !ready_o);

    assert_no_ready_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        !(ready_o && done_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_then_ready_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> ready_o);

    assert_parity_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(parity_o));

    assert_busy_ignores_start_R5: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !done_o) |=> !ready_o);

endmodule

bind hdr_parity_gen hdr_parity_chk #(.PAR_W(PAR_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .parity_o(parity_o)
);

// File: tb/test_hdr_parity_gen.sv
module test_hdr_parity_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        ready_o, done_o;
    logic [7:0]  parity_o;
    logic [7:0]  hdr1_i = '0, hdr2_i = '0, hdr3_i = '0;
    logic [7:0]  par1_i = '0, par2_i = '0, par3_i = '0;
    logic [31:0] pack_a_o, pack_b_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit checking = 0;
    bit ended    = 0;

    // reference model state
    int       m_busy = 0;
    logic [7:0] m_par = '0;
    logic [7:0] m_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_parity_gen i_hdr_parity_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
        .ready_o(ready_o), .done_o(done_o), .parity_o(parity_o),
        .hdr1_i(hdr1_i), .hdr2_i(hdr2_i), .hdr3_i(hdr3_i),
        .par1_i(par1_i), .par2_i(par2_i), .par3_i(par3_i),
        .pack_a_o(pack_a_o), .pack_b_o(pack_b_o)
    );

    function automatic logic [3:0] map_bits(input logic [3:0] c, input bit upper);
        logic [3:0] g;
        if (upper) begin
            g[0] = c[3]; g[1] = c[0] ^ c[3]; g[2] = c[1]; g[3] = c[2];
        end else begin
            g[0] = c[0] ^ c[3]; g[1] = c[0] ^ c[1] ^ c[3];
            g[2] = c[1] ^ c[2]; g[3] = c[2] ^ c[3];
        end
        return g;
    endfunction

    function automatic int steps_for(input logic [31:0] w);
        return (w > 32'hFF) ? 8 : 2;
    endfunction

    function automatic logic [7:0] ref_parity(input logic [31:0] w);
        logic [3:0] a = '0, b = '0, c, nib;
        int n = steps_for(w);
        for (int i = 0; i < n; i++) begin
            nib = 4'((w >> (4 * i)) & 32'hF);
            c = nib ^ b;
            b = a ^ map_bits(c, 1'b0);
            a = map_bits(c, 1'b1);
        end
        return {a, b};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // cycle model, inputs are stable at the rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0;
            m_par  = '0;
        end else if (m_busy == 0) begin
            if (start_i) begin
                m_busy = steps_for(word_i) + 1;
                m_pend = ref_parity(word_i);
            end
        end else begin
            m_busy--;
            if (m_busy == 1) m_par = m_pend;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (checking && !rst) begin
            check(ready_o == (m_busy == 0), "R4/R5", "ready_o", 32'(ready_o), 32'(m_busy == 0));
            check(done_o == (m_busy == 1), "R4/R6", "done_o", 32'(done_o), 32'(m_busy == 1));
            check(parity_o == m_par, "R1/R2/R3/R6", "parity_o", 32'(parity_o), 32'(m_par));
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic run_one(input logic [31:0] w);
        int cyc = 0;
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        word_i  = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == steps_for(w) + 1, "R1", "cycles to done", 32'(cyc), 32'(steps_for(w) + 1));
        check(parity_o == ref_parity(w), "R2/R3", "parity", 32'(parity_o), 32'(ref_parity(w)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checking = 1;
        // R7: state after reset
        check(ready_o == 1'b1, "R7", "ready after reset", 32'(ready_o), 32'd1);
        check(done_o == 1'b0, "R7", "done after reset", 32'(done_o), 32'd0);
        check(parity_o == 8'h00, "R7", "parity after reset", 32'(parity_o), 32'd0);

        run_one(32'h0000_0000);
        check(parity_o == 8'h00, "R2", "zero word parity", 32'(parity_o), 32'd0);
        run_one(32'h0000_00FF);
        run_one(32'h0000_0100);
        run_one(32'hFFFF_FFFF);
        run_one(32'h0000_0001);
        for (int i = 0; i < 30; i++) run_one($urandom);

        // R5: start pulses with new words while busy
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            while (!ready_o) @(negedge clk);
            word_i = $urandom;
            start_i = 1'b1;
            @(negedge clk);
            word_i = $urandom;
            repeat (3) @(negedge clk);
            word_i = $urandom;
            start_i = 1'b0;
        end

        // back-to-back: start held high, word changing every cycle
        @(negedge clk);
        start_i = 1'b1;
        for (int i = 0; i < 80; i++) begin
            word_i = (i % 3 == 0) ? ($urandom & 32'hFF) : $urandom;
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (12) @(negedge clk);

        // R7: reset in the middle of a run
        word_i  = 32'hDEAD_BEEF;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(ready_o == 1'b1, "R7", "ready after mid-run reset", 32'(ready_o), 32'd1);
        check(done_o == 1'b0, "R7", "done after mid-run reset", 32'(done_o), 32'd0);
        check(parity_o == 8'h00, "R7", "parity after mid-run reset", 32'(parity_o), 32'd0);
        run_one(32'h1234_5678);

        // R8 / R9: packer images
        for (int i = 0; i < 8; i++) begin
            {hdr1_i, hdr2_i, hdr3_i} = 24'($urandom);
            {par1_i, par2_i, par3_i} = 24'($urandom);
            #1;
            check(pack_a_o == {par1_i, hdr1_i, par2_i, hdr2_i}, "R8", "pack_a_o",
                  pack_a_o, {par1_i, hdr1_i, par2_i, hdr2_i});
            check(pack_b_o == {par3_i, hdr3_i, 16'h0000}, "R9", "pack_b_o",
                  pack_b_o, {par3_i, hdr3_i, 16'h0000});
        end

        repeat (2) @(negedge clk);
        summary();
    end

endmodule